// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address for each access of a synchronous memory port. In every clock cycle it picks one of four sources: zero, the address presented on the external bus, the previous address plus one, or the previous address unchanged. The choice is made through three active-low controls: clear, load and advance. Clear beats load, and load beats advance. The selected address is driven out in the same cycle it is chosen, so the memory can use it for that cycle's access. The block also keeps a registered copy of that address, which becomes the base for the following cycle.

The three controls ignore chip selection entirely. The address still moves in cycles where the port is deselected. The chip select is only passed on to the memory as an access enable. Clearing costs no dead cycle, because the zero address is available for an access in the same cycle as the clear. The address width is a parameter, 16 bits by default.

Top module: `burst_addr_gen`

## Requirements
- R1: When `clrN` is low, `curAddr` is 0 in that cycle and `baseAddr` is 0 after the next rising edge, whatever `loadN`, `advN` and `extAddr` are.
- R2: When `clrN` is high and `loadN` is low, `curAddr` equals `extAddr` in that cycle, whatever `advN` is. After the edge, `baseAddr` holds that value.
- R3: When `clrN` and `loadN` are high and `advN` is low, `curAddr` equals `baseAddr + 1` in that cycle. The access of that cycle therefore uses the advanced address.
- R4: When all three controls are high, `curAddr` equals `baseAddr` and `baseAddr` stays unchanged across the edge. Any value on `extAddr` has no effect.
- R5: Advancing from the all-ones address gives 0.
- R6: `selN` (active low) has no effect on `curAddr` or `baseAddr`. `accessEn` is 1 exactly when `selN` is 0.
- R7: A clock edge with `rstN` low sets `baseAddr` to 0. This reset is synchronous and active low.
- R8: After each rising edge outside reset, `baseAddr` equals the value `curAddr` had just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous system reset, active low |
| extAddr | input | AW | Externally presented address |
| loadN | input | 1 | Load external address, active low |
| advN | input | 1 | Advance address by one, active low |
| clrN | input | 1 | Clear address to zero, active low, highest priority |
| selN | input | 1 | Chip select, active low, forwarded only |
| curAddr | output | AW | Address used by the current cycle's access |
| baseAddr | output | AW | Registered address, base for the next cycle |
| accessEn | output | 1 | Access enable for the memory, high when selected |

## Verification
On every cycle the assertions check the relation between the controls and the next registered address. They cover clear to zero, load from the bus, advance by one with wrap, hold, and the registered copy tracking the current address. Two things only the directed scenarios can show:
- The combinational same-cycle value of `curAddr`, including the absence of a dead cycle on clear.
- The independence from `selN`, shown by driving identical control sequences with the port selected and with it deselected and comparing the results.

// File: rtl/addrgen_pkg.sv
package addrgen_pkg;
  // One-hot strobes from the decoder; all zero means hold.
  typedef struct packed {
    logic clr;
    logic load;
    logic adv;
  } strobe_t;
endpackage

// File: rtl/addrgen_ctl.sv
module addrgen_ctl
  import addrgen_pkg::*;
(
  input  logic    clrN,
  input  logic    loadN,
  input  logic    advN,
  output strobe_t stb
);
  // Fixed priority: clear, then load, then advance.
  always_comb begin
    stb = '0;
    if (!clrN)       stb.clr  = 1'b1;
    else if (!loadN) stb.load = 1'b1;
    else if (!advN)  stb.adv  = 1'b1;
  end
endmodule

// File: rtl/addrgen_dp.sv
module addrgen_dp
  import addrgen_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [AW-1:0] extAddr,
  output logic [AW-1:0] curAddr,
  output logic [AW-1:0] baseAddr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] incAddr;

  // Natural modulo-2^AW increment gives the wrap to zero.
  assign incAddr = baseAddr + ONE;

  always_comb begin
    if (stb.clr)       curAddr = '0;
    else if (stb.load) curAddr = extAddr;
    else if (stb.adv)  curAddr = incAddr;
    else               curAddr = baseAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) baseAddr <= '0;
    else       baseAddr <= curAddr;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import addrgen_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] extAddr,
  input  logic          loadN,
  input  logic          advN,
  input  logic          clrN,
  input  logic          selN,
  output logic [AW-1:0] curAddr,
  output logic [AW-1:0] baseAddr,
  output logic          accessEn
);
  strobe_t stb;

  addrgen_ctl u_ctl (
    .clrN  (clrN),
    .loadN (loadN),
    .advN  (advN),
    .stb   (stb)
  );

  addrgen_dp #(.AW(AW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .extAddr  (extAddr),
    .curAddr  (curAddr),
    .baseAddr (baseAddr)
  );

  // Chip select is forwarded only; it never gates the address path.
  assign accessEn = ~selN;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] extAddr,
  input logic          loadN,
  input logic          advN,
  input logic          clrN,
  input logic          selN,
  input logic [AW-1:0] curAddr,
  input logic [AW-1:0] baseAddr,
  input logic          accessEn
);
  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |=> baseAddr == '0);

  a_r2_load_ext: assert property (@(posedge clk) disable iff (!rstN)
    (clrN && !loadN) |=> baseAddr == $past(extAddr));

  // R3 and R5: advance by one, modulo the address width.
  a_r3_advance: assert property (@(posedge clk) disable iff (!rstN)
    (clrN && loadN && !advN) |=> baseAddr == AW'($past(baseAddr) + AW'(1)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (clrN && loadN && advN) |=> $stable(baseAddr));

  a_r6_enable: assert property (@(posedge clk) disable iff (!rstN)
    accessEn != selN);

  a_r8_track: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> baseAddr == $past(curAddr));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .extAddr(extAddr), .loadN(loadN), .advN(advN),
  .clrN(clrN), .selN(selN), .curAddr(curAddr), .baseAddr(baseAddr),
  .accessEn(accessEn)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic          loadN = 1'b1, advN = 1'b1, clrN = 1'b1, selN = 1'b1;
  logic [AW-1:0] curAddr, baseAddr;
  logic          accessEn;

  int checks = 0;
  int failures = 0;
  logic [AW-1:0] refBase = '0;
  logic [AW-1:0] trace0 [0:7];
  logic [AW-1:0] trace1 [0:7];

  always #10 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u_burst_addr_gen (
    .clk(clk), .rstN(rstN), .extAddr(extAddr), .loadN(loadN), .advN(advN),
    .clrN(clrN), .selN(selN), .curAddr(curAddr), .baseAddr(baseAddr),
    .accessEn(accessEn)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle after a falling edge, check the same-cycle address,
  // then check the registered copy after the rising edge.
  task automatic step(input logic c, input logic l, input logic a,
                      input logic [AW-1:0] ext, input logic s, input string req);
    logic [AW-1:0] exp;
    @(negedge clk);
    clrN = c; loadN = l; advN = a; extAddr = ext; selN = s;
    if (!c)      exp = '0;
    else if (!l) exp = ext;
    else if (!a) exp = refBase + 1'b1;
    else         exp = refBase;
    #2;
    check(req, curAddr, exp);
    check("R6", {{(AW-1){1'b0}}, accessEn}, {{(AW-1){1'b0}}, ~s});
    @(posedge clk); #2;
    check("R8", baseAddr, exp);
    refBase = exp;
  endtask

  task automatic t_reset();
    @(negedge clk); rstN = 1'b0; extAddr = 16'h1234; loadN = 1'b0;
    @(posedge clk); #2;
    check("R7", baseAddr, '0);
    @(negedge clk); rstN = 1'b1; loadN = 1'b1;
    refBase = '0;
  endtask

  task automatic t_load();
    step(1, 0, 1, 16'h00A5, 0, "R2");
    step(1, 0, 0, 16'h3C00, 0, "R2");   // load wins over advance
    step(1, 0, 0, 16'h3C00, 1, "R2");
  endtask

  task automatic t_advance();
    step(1, 0, 1, 16'h0100, 0, "R2");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 16'hDEAD, 0, "R3");
    check("R3", refBase, 16'h0104);
  endtask

  task automatic t_hold();
    step(1, 0, 1, 16'h0777, 0, "R2");
    step(1, 1, 1, 16'hBEEF, 0, "R4");
    step(1, 1, 1, 16'h0001, 1, "R4");
    check("R4", baseAddr, 16'h0777);
  endtask

  task automatic t_clear();
    step(1, 0, 1, 16'h5555, 0, "R2");
    step(0, 0, 0, 16'hAAAA, 0, "R1");   // clear beats load and advance
    step(1, 1, 0, 16'hAAAA, 0, "R3");   // next access is address 1
    step(0, 1, 1, 16'h0000, 1, "R1");
  endtask

  task automatic t_wrap();
    step(1, 0, 1, 16'hFFFE, 0, "R2");
    step(1, 1, 0, 16'h0000, 0, "R5");
    step(1, 1, 0, 16'h0000, 0, "R5");
    check("R5", baseAddr, 16'h0000);
  endtask

  // Same control sequence selected and deselected must give equal addresses.
  task automatic t_deselect();
    for (int pass = 0; pass < 2; pass++) begin
      step(0, 1, 1, 16'h0000, logic'(pass), "R6");
      step(1, 0, 1, 16'h0200, logic'(pass), "R6");
      for (int i = 0; i < 3; i++) step(1, 1, 0, 16'h0000, logic'(pass), "R6");
      for (int i = 0; i < 5; i++) begin
        if (pass == 0) trace0[i] = baseAddr; else trace1[i] = baseAddr;
        step(1, 1, logic'(i[0]), 16'h0F0F, logic'(pass), "R6");
      end
    end
    for (int i = 0; i < 5; i++) check("R6", trace1[i], trace0[i]);
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r[0] | r[1], r[2], r[3], AW'($urandom), logic'($urandom), "R8");
    end
  endtask

  initial begin
    void'($urandom(7));
    t_reset();
    t_load();
    t_advance();
    t_hold();
    t_clear();
    t_wrap();
    t_deselect();
    t_random();
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule